// File: doc/BRIEF.md
# VLAN Violation Capture Unit

The unit sits beside a switch's VLAN lookup and records policy violations that the forwarding path reports. Each report carries the frame's VLAN ID, the ingress port number and two type flags: a member flag (the ingress port does not belong to that VLAN) and a miss flag (the VLAN ID has no table entry). One report at a time is held in a single capture slot, and while the slot is full a level interrupt is raised towards the host.

Software empties the slot with a get-and-clear command. The command shares the busy-flagged handshake of the VLAN table's other commands: a start pulse raises a busy bit for a fixed number of cycles. When the busy bit drops, the result word holds the port number and type flags of the captured violation, the VLAN ID register holds its VLAN ID, the slot is empty and the interrupt falls. Reports that arrive while the slot is full are dropped, not queued. A sticky lost flag records the drop and is returned, then cleared, by the next get-and-clear.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset `irq` is low and `op_word` and `vid_word` are all zero.
- R2: A report (`rpt_valid` high for one cycle) that arrives while no violation is pending is captured, and `irq` is high from the next cycle.
- R3: `irq` stays high until a get-and-clear command completes; nothing else lowers it.
- R4: `cmd_go` while `op_word[15]` (busy) is low starts a get-and-clear: busy is high for exactly OP_CYCLES cycles; `cmd_go` while busy is high is ignored.
- R5: On completion the result word holds the source port in bits 3:0, the miss flag in bit 5 and the member flag in bit 6, `vid_word` holds the VLAN ID, and `irq` is low unless R9 applies.
- R6: A report that arrives while a violation is pending is ignored: the next get-and-clear returns the first report's port, VLAN ID and flags.
- R7: A report ignored under R6 sets the lost flag, returned in result bit 7; a completed get-and-clear clears it.
- R8: A get-and-clear with no violation pending returns port, flags, lost bit and VLAN ID all zero.
- R9: A report arriving in the cycle in which a get-and-clear completes is captured after the clear: it is not lost and `irq` stays high.
- R10: Result bits 14:0 and `vid_word` change only at the completion of a get-and-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Violation report strobe from the forwarding path |
| rpt_vid | input | VID_W | VLAN ID of the offending frame |
| rpt_port | input | PORT_W | Ingress port of the offending frame |
| rpt_member | input | 1 | Report type: port not a member of the VLAN |
| rpt_miss | input | 1 | Report type: VLAN ID not in the table |
| cmd_go | input | 1 | Start a get-and-clear command |
| irq | output | 1 | Level interrupt, high while a violation is pending |
| op_word | output | 16 | Bit 15 busy, bit 7 lost, bit 6 member, bit 5 miss, bits 3:0 port |
| vid_word | output | VID_W | VLAN ID returned by the last get-and-clear |

## Verification
The bench uses the default widths: a 12-bit VLAN ID and a 4-bit port, so the extreme IDs 0 and 4095 and ports 0 and 15 are driven through the real field positions. OP_CYCLES is set to 3, which leaves room to issue a second `cmd_go` while busy and to put a report exactly on the completion cycle. A scoreboard queue holds the expected result of each get-and-clear and is compared when busy falls.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int RES_W       = 16;
  localparam int BIT_BUSY    = 15;
  localparam int BIT_LOST    = 7;
  localparam int BIT_MEMBER  = 6;
  localparam int BIT_MISS    = 5;
  localparam int PORT_FIELD  = 4;

  typedef struct packed {
    logic member;
    logic miss;
  } vvc_kind_t;
endpackage

// File: rtl/vvc_slot.sv
module vvc_slot
  import vvc_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_valid,
  input  logic [VID_W-1:0]  rpt_vid,
  input  logic [PORT_W-1:0] rpt_port,
  input  vvc_kind_t         rpt_kind,
  input  logic              take,
  output logic              pending,
  output logic              lost,
  output logic [VID_W-1:0]  s_vid,
  output logic [PORT_W-1:0] s_port,
  output vvc_kind_t         s_kind
);
  // A take in the same cycle frees the slot before a new report lands.
  logic room;
  assign room = !pending || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      lost    <= 1'b0;
      s_vid   <= '0;
      s_port  <= '0;
      s_kind  <= '0;
    end else begin
      if (take) begin
        pending <= 1'b0;
        lost    <= 1'b0;
      end
      if (rpt_valid) begin
        if (room) begin
          pending <= 1'b1;
          s_vid   <= rpt_vid;
          s_port  <= rpt_port;
          s_kind  <= rpt_kind;
        end else begin
          lost <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vvc_opseq.sv
module vvc_opseq #(
  parameter int OP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_go,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (cmd_go) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(OP_CYCLES - 1);
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/vvc_result.sv
module vvc_result
  import vvc_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              pending,
  input  logic              lost,
  input  logic [VID_W-1:0]  s_vid,
  input  logic [PORT_W-1:0] s_port,
  input  vvc_kind_t         s_kind,
  output logic [RES_W-2:0]  res_bits,
  output logic [VID_W-1:0]  res_vid
);
  logic [RES_W-2:0] packed_bits;

  always_comb begin
    packed_bits = '0;
    if (pending) begin
      packed_bits[PORT_W-1:0] = s_port;
      packed_bits[BIT_MISS]   = s_kind.miss;
      packed_bits[BIT_MEMBER] = s_kind.member;
      packed_bits[BIT_LOST]   = lost;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_bits <= '0;
      res_vid  <= '0;
    end else if (done) begin
      res_bits <= packed_bits;
      res_vid  <= pending ? s_vid : '0;
    end
  end
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vvc_pkg::*;
#(
  parameter int VID_W     = 12,
  parameter int PORT_W    = 4,
  parameter int OP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_valid,
  input  logic [VID_W-1:0]  rpt_vid,
  input  logic [PORT_W-1:0] rpt_port,
  input  logic              rpt_member,
  input  logic              rpt_miss,
  input  logic              cmd_go,
  output logic              irq,
  output logic [15:0]       op_word,
  output logic [VID_W-1:0]  vid_word
);
  logic              busy;
  logic              done;
  logic              pending;
  logic              slot_lost;
  logic [VID_W-1:0]  s_vid;
  logic [PORT_W-1:0] s_port;
  vvc_kind_t         s_kind;
  vvc_kind_t         in_kind;
  logic [RES_W-2:0]  res_bits;

  assign in_kind.member = rpt_member;
  assign in_kind.miss   = rpt_miss;

  vvc_opseq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .cmd_go (cmd_go),
    .busy   (busy),
    .done   (done)
  );

  vvc_slot #(.VID_W(VID_W), .PORT_W(PORT_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .rpt_valid (rpt_valid),
    .rpt_vid   (rpt_vid),
    .rpt_port  (rpt_port),
    .rpt_kind  (in_kind),
    .take      (done),
    .pending   (pending),
    .lost      (slot_lost),
    .s_vid     (s_vid),
    .s_port    (s_port),
    .s_kind    (s_kind)
  );

  vvc_result #(.VID_W(VID_W), .PORT_W(PORT_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .pending  (pending),
    .lost     (slot_lost),
    .s_vid    (s_vid),
    .s_port   (s_port),
    .s_kind   (s_kind),
    .res_bits (res_bits),
    .res_vid  (vid_word)
  );

  assign irq     = pending;
  assign op_word = {busy, res_bits};
endmodule

// File: rtl/vvc_checker.sv
module vvc_checker #(
  parameter int VID_W     = 12,
  parameter int OP_CYCLES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rpt_valid,
  input logic             cmd_go,
  input logic             irq,
  input logic [15:0]      op_word,
  input logic [VID_W-1:0] vid_word,
  input logic             slot_lost
);
  logic        busy;
  logic [15:0] run;

  assign busy = op_word[15];

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !irq) |=> irq);

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (irq && !busy) |=> irq);

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < 16'(OP_CYCLES)));

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(run) == 16'(OP_CYCLES - 1)));

  assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_go));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rpt_valid)) |-> !irq);

  assert_lost_set_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && rpt_valid && !busy) |=> slot_lost);

  assert_result_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(op_word[14:0]) && $stable(vid_word)));
endmodule

bind vlan_viol_capture vvc_checker #(.VID_W(VID_W), .OP_CYCLES(OP_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rpt_valid (rpt_valid),
  .cmd_go    (cmd_go),
  .irq       (irq),
  .op_word   (op_word),
  .vid_word  (vid_word),
  .slot_lost (slot_lost)
);

// File: tb/sim_vlan_viol_capture.sv
`timescale 1ns/1ps
module sim_vlan_viol_capture;
  localparam int VID_W  = 12;
  localparam int PORT_W = 4;
  localparam int OPC    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rpt_valid = 1'b0;
  logic [VID_W-1:0]  rpt_vid = '0;
  logic [PORT_W-1:0] rpt_port = '0;
  logic              rpt_member = 1'b0;
  logic              rpt_miss = 1'b0;
  logic              cmd_go = 1'b0;
  logic              irq;
  logic [15:0]       op_word;
  logic [VID_W-1:0]  vid_word;

  int checks = 0;
  int fails  = 0;
  logic [14+VID_W:0] exp_q[$];
  logic prev_busy = 1'b0;

  always #2.5 clk = ~clk;

  vlan_viol_capture #(.VID_W(VID_W), .PORT_W(PORT_W), .OP_CYCLES(OPC)) u0 (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_vid(rpt_vid),
    .rpt_port(rpt_port), .rpt_member(rpt_member), .rpt_miss(rpt_miss),
    .cmd_go(cmd_go), .irq(irq), .op_word(op_word), .vid_word(vid_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares each completed get-and-clear against the scoreboard.
  always @(negedge clk) begin
    if (!rst && prev_busy && !op_word[15]) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: actual %0h/%0h expected none queued", op_word[14:0], vid_word);
      end else begin
        logic [14+VID_W:0] e;
        e = exp_q.pop_front();
        if ({op_word[14:0], vid_word} !== e) begin
          fails++;
          $display("FAIL R5/R6/R7/R8/R9: actual %0h/%0h expected %0h/%0h",
                   op_word[14:0], vid_word, e[14+VID_W:VID_W], e[VID_W-1:0]);
        end
      end
    end
    prev_busy = op_word[15];
  end

  task automatic report(input logic [VID_W-1:0] v, input logic [PORT_W-1:0] p,
                        input logic mem, input logic mis);
    @(negedge clk);
    rpt_valid = 1'b1; rpt_vid = v; rpt_port = p; rpt_member = mem; rpt_miss = mis;
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  // Driver: queues the expected result, runs one get-and-clear.
  // extra_go repeats cmd_go while busy; late_* drives a report on the completion cycle.
  task automatic getclr(input logic [14:0] ew, input logic [VID_W-1:0] ev,
                        input logic extra_go, input logic late_en,
                        input logic [VID_W-1:0] lv, input logic [PORT_W-1:0] lp,
                        input logic lmem, input logic lmis);
    int n;
    exp_q.push_back({ew, ev});
    @(negedge clk);
    cmd_go = 1'b1;
    @(negedge clk);
    n = 0;
    while (op_word[15] && n < 20) begin
      n++;
      cmd_go = extra_go && (n == 1);
      if (late_en && n == OPC) begin
        rpt_valid = 1'b1; rpt_vid = lv; rpt_port = lp; rpt_member = lmem; rpt_miss = lmis;
      end else begin
        rpt_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_go = 1'b0;
    rpt_valid = 1'b0;
    check("R4 busy length", 32'(n), 32'(OPC));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] snap_w;
    logic [VID_W-1:0] snap_v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 op_word", 32'(op_word), 0);
    check("R1 vid_word", 32'(vid_word), 0);

    // R2, R3, R5: member violation, vid 0x123, port 5
    report(12'h123, 4'd5, 1'b1, 1'b0);
    check("R2 irq after report", 32'(irq), 1);
    repeat (5) @(negedge clk);
    check("R3 irq held", 32'(irq), 1);
    getclr(15'h0045, 12'h123, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R5 irq cleared", 32'(irq), 0);

    // R6, R7, R10: first report kept, second dropped, lost flag set
    report(12'hFFF, 4'd15, 1'b0, 1'b1);
    snap_w = op_word; snap_v = vid_word;
    report(12'h007, 4'd2, 1'b1, 1'b0);
    check("R10 result word unchanged", 32'(op_word), 32'(snap_w));
    check("R10 vid unchanged", 32'(vid_word), 32'(snap_v));
    check("R6 irq still high", 32'(irq), 1);
    getclr(15'h00AF, 12'hFFF, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);

    // R8 and R7 clear: nothing pending, lost cleared
    getclr(15'h0000, 12'h000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R8 irq low", 32'(irq), 0);

    // R4: cmd_go repeated while busy is ignored
    report(12'h00A, 4'd3, 1'b0, 1'b1);
    getclr(15'h0023, 12'h00A, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R4 no second command", 32'(op_word[15]), 0);

    // R9: report on completion cycle survives the clear; both flags, vid 0, port 0
    report(12'h055, 4'd1, 1'b1, 1'b0);
    getclr(15'h0041, 12'h055, 1'b0, 1'b1, 12'h000, 4'd0, 1'b1, 1'b1);
    check("R9 irq kept by late report", 32'(irq), 1);
    getclr(15'h0060, 12'h000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    check("R9 irq low after second clear", 32'(irq), 0);

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule